// File: doc/BRIEF.md
# Fixed-Point Add Execute Unit

This unit accepts one 32-bit instruction word per cycle, qualified by a valid strobe, and executes it when it encodes the register-to-register signed add. It owns a register file of 32 general-purpose 32-bit registers, a three-bit fixed-point exception status (summary overflow, overflow, carry) and a four-bit condition field 0.

Two flag bits inside the instruction word choose the variant. The overflow-enable flag lets the instruction update the overflow status. The record flag lets it write the condition field from the sign of the result. Summary overflow is sticky and is also copied into the condition field. The carry bit belongs to the same status register, but this instruction never changes it. Any other word raises an illegal-instruction flag and leaves all state alone.

Outside test logic uses a test port to load registers before execution and to read them back afterwards. Each executed add also shows its register write on a result port.

Top module: `fxadd_exec`

## Requirements
- R1: Bit positions use word bits 31 (MSB) down to 0. A word is legal only when bits [31:26] equal 31 and bits [9:1] equal 266. The target index is bits [25:21], source A is bits [20:16], source B is bits [15:11], overflow-enable is bit 10 and record is bit 0.
- R2: A legal valid word writes the 32-bit wrapped sum of sources A and B into the target register. On the next clock edge, `gpr_we_o` pulses for one cycle with `gpr_waddr_o` equal to the target and `gpr_wdata_o` equal to the sum. The target then reads back through the test port.
- R3: The sources are read as they stood before the instruction's own write, so a target that equals a source gets the sum of the old values.
- R4: With overflow-enable 1, `xer_ov_o` becomes 1 exactly when both operands have the same sign and the sum's sign differs, and otherwise becomes 0. With overflow-enable 0, `xer_ov_o` and `xer_so_o` hold.
- R5: `xer_so_o` becomes the OR of its old value and the new overflow. This instruction never clears it.
- R6: With record 1, `cr0_o` becomes {LT, GT, EQ, SO} in bits [3:0]. LT, GT and EQ give the signed comparison of the sum with zero, so exactly one of them is set. SO is the summary overflow after this instruction's update. With record 0, `cr0_o` holds.
- R7: `xer_ca_o` is never changed by any instruction, so it stays 0 after reset.
- R8: A valid word that is not legal pulses `illegal_o` on the next edge and changes no register, status or condition bit. A word with valid low does nothing.
- R9: Reset (`rst_n` low) clears the status bits, the condition field, `gpr_we_o` and `illegal_o`.
- R10: The test port writes `tp_wdata_i` to register `tp_addr_i` on a clock edge when `tp_we_i` is high. `tp_rdata_o` shows register `tp_addr_i` combinationally. If an executed add targets the same register on the same edge, the add's result is the one stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| instr_valid_i | input | 1 | Instruction word valid |
| instr_i | input | 32 | Instruction word |
| tp_we_i | input | 1 | Test port register write enable |
| tp_addr_i | input | 5 | Test port register index (read and write) |
| tp_wdata_i | input | 32 | Test port write data |
| tp_rdata_o | output | 32 | Test port read data, combinational |
| gpr_we_o | output | 1 | Register write pulse of an executed add |
| gpr_waddr_o | output | 5 | Index written by the executed add |
| gpr_wdata_o | output | 32 | Value written by the executed add |
| xer_so_o | output | 1 | Summary overflow, sticky |
| xer_ov_o | output | 1 | Overflow |
| xer_ca_o | output | 1 | Carry, never changed by this unit |
| cr0_o | output | 4 | Condition field 0 as {LT, GT, EQ, SO} |
| illegal_o | output | 1 | Illegal-word pulse |

## Verification
Every result of an instruction presented in one cycle appears on the next rising edge: the write pulse, status, condition field, illegal flag and register contents. The bench drives a word on a falling edge and removes it on the next falling edge. It samples every output at that second falling edge, which is half a cycle after the update. Register contents are read through the combinational test port at the same point. Test-port loads are likewise checked one edge after they are driven.

// File: rtl/fxadd_pkg.sv
package fxadd_pkg;

  localparam int IDX_W = 5;
  localparam int PRI_W = 6;
  localparam int EXT_W = 9;

  localparam logic [PRI_W-1:0] PRI_ADD = 6'd31;
  localparam logic [EXT_W-1:0] EXT_ADD = 9'd266;

  typedef struct packed {
    logic             legal;
    logic [IDX_W-1:0] rt;
    logic [IDX_W-1:0] ra;
    logic [IDX_W-1:0] rb;
    logic             oe;
    logic             rc;
  } dec_t;

  typedef struct packed {
    logic so;
    logic ov;
    logic ca;
  } xer_t;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cr_t;

endpackage

// File: rtl/fxadd_dec.sv
module fxadd_dec
  import fxadd_pkg::*;
(
  input  logic [31:0] word_i,
  output dec_t        dec_o
);

  logic [PRI_W-1:0] pri;
  logic [EXT_W-1:0] ext;

  // Fields are taken with bit 31 as the most significant bit of the word.
  always_comb begin
    pri         = word_i[31:26];
    ext         = word_i[9:1];
    dec_o.rt    = word_i[25:21];
    dec_o.ra    = word_i[20:16];
    dec_o.rb    = word_i[15:11];
    dec_o.oe    = word_i[10];
    dec_o.rc    = word_i[0];
    dec_o.legal = (pri == PRI_ADD) && (ext == EXT_ADD);
  end

endmodule

// File: rtl/fxadd_gpr.sv
module fxadd_gpr #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic [AW-1:0]   ra_addr_i,
  output logic [XLEN-1:0] ra_data_o,
  input  logic [AW-1:0]   rb_addr_i,
  output logic [XLEN-1:0] rb_data_o,
  input  logic [AW-1:0]   rt_addr_i,
  output logic [XLEN-1:0] rt_data_o,
  input  logic            we_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [XLEN-1:0] wdata_i
);

  logic [XLEN-1:0] mem_q [NREG];
  logic [NREG-1:0] row_en;

  // One-hot row enables; the datapath storage carries no reset.
  generate
    for (genvar g = 0; g < NREG; g++) begin : g_row
      assign row_en[g] = we_i && (waddr_i == AW'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (row_en[i]) mem_q[i] <= wdata_i;
    end
  end

  assign ra_data_o = mem_q[ra_addr_i];
  assign rb_data_o = mem_q[rb_addr_i];
  assign rt_data_o = mem_q[rt_addr_i];

endmodule

// File: rtl/fxadd_alu.sv
module fxadd_alu #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] sum_o,
  output logic            ovf_o,
  output logic            lt_o,
  output logic            gt_o,
  output logic            eq_o
);

  localparam int MSB = XLEN - 1;

  always_comb begin
    sum_o = a_i + b_i;
    // Signed overflow: operands agree in sign, result disagrees.
    ovf_o = (a_i[MSB] ~^ b_i[MSB]) & (sum_o[MSB] ^ a_i[MSB]);
    eq_o  = ~|sum_o;
    lt_o  = sum_o[MSB];
    gt_o  = ~sum_o[MSB] & ~eq_o;
  end

endmodule

// File: rtl/fxadd_exec.sv
module fxadd_exec
  import fxadd_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_valid_i,
  input  logic [31:0]     instr_i,
  input  logic            tp_we_i,
  input  logic [AW-1:0]   tp_addr_i,
  input  logic [XLEN-1:0] tp_wdata_i,
  output logic [XLEN-1:0] tp_rdata_o,
  output logic            gpr_we_o,
  output logic [AW-1:0]   gpr_waddr_o,
  output logic [XLEN-1:0] gpr_wdata_o,
  output logic            xer_so_o,
  output logic            xer_ov_o,
  output logic            xer_ca_o,
  output logic [3:0]      cr0_o,
  output logic            illegal_o
);

  dec_t            dec;
  logic [XLEN-1:0] opa, opb, sum;
  logic            ovf, res_lt, res_gt, res_eq;
  logic            fire, reject;

  logic            rf_we;
  logic [AW-1:0]   rf_waddr;
  logic [XLEN-1:0] rf_wdata;

  xer_t            xer_q, xer_n;
  cr_t             cr_q, cr_n;
  logic            we_q, we_n;
  logic [AW-1:0]   waddr_q, waddr_n;
  logic [XLEN-1:0] wdata_q, wdata_n;
  logic            ill_q, ill_n;
  logic            res_en;

  fxadd_dec u_dec (
    .word_i (instr_i),
    .dec_o  (dec)
  );

  fxadd_gpr #(.XLEN(XLEN), .NREG(NREG)) u_gpr (
    .clk       (clk),
    .ra_addr_i (dec.ra[AW-1:0]),
    .ra_data_o (opa),
    .rb_addr_i (dec.rb[AW-1:0]),
    .rb_data_o (opb),
    .rt_addr_i (tp_addr_i),
    .rt_data_o (tp_rdata_o),
    .we_i      (rf_we),
    .waddr_i   (rf_waddr),
    .wdata_i   (rf_wdata)
  );

  fxadd_alu #(.XLEN(XLEN)) u_alu (
    .a_i   (opa),
    .b_i   (opb),
    .sum_o (sum),
    .ovf_o (ovf),
    .lt_o  (res_lt),
    .gt_o  (res_gt),
    .eq_o  (res_eq)
  );

  assign fire   = instr_valid_i & dec.legal;
  assign reject = instr_valid_i & ~dec.legal;

  // Register file write port: an executed add takes precedence over the test port.
  always_comb begin
    rf_we    = fire | tp_we_i;
    rf_waddr = fire ? dec.rt[AW-1:0] : tp_addr_i;
    rf_wdata = fire ? sum : tp_wdata_i;
  end

  // Next state of status, condition field and result port.
  always_comb begin
    xer_n    = xer_q;
    cr_n     = cr_q;
    we_n     = fire;
    ill_n    = reject;
    res_en   = fire;
    waddr_n  = dec.rt[AW-1:0];
    wdata_n  = sum;
    if (fire && dec.oe) begin
      xer_n.ov = ovf;
      xer_n.so = xer_q.so | ovf;
    end
    if (fire && dec.rc) begin
      cr_n.lt = res_lt;
      cr_n.gt = res_gt;
      cr_n.eq = res_eq;
      cr_n.so = xer_n.so;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xer_q <= '0;
      cr_q  <= '0;
      we_q  <= 1'b0;
      ill_q <= 1'b0;
    end else begin
      xer_q <= xer_n;
      cr_q  <= cr_n;
      we_q  <= we_n;
      ill_q <= ill_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waddr_q <= '0;
      wdata_q <= '0;
    end else if (res_en) begin
      waddr_q <= waddr_n;
      wdata_q <= wdata_n;
    end
  end

  assign gpr_we_o    = we_q;
  assign gpr_waddr_o = waddr_q;
  assign gpr_wdata_o = wdata_q;
  assign xer_so_o    = xer_q.so;
  assign xer_ov_o    = xer_q.ov;
  assign xer_ca_o    = xer_q.ca;
  assign cr0_o       = cr_q;
  assign illegal_o   = ill_q;

endmodule

// File: rtl/fxadd_exec_chk.sv
module fxadd_exec_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          vld,
  input logic [5:0]    pri,
  input logic [8:0]    ext,
  input logic [4:0]    rt,
  input logic          oe,
  input logic          rc,
  input logic          we,
  input logic [AW-1:0] waddr,
  input logic          so,
  input logic          ov,
  input logic          ca,
  input logic [3:0]    cr,
  input logic          ill
);

  logic legal;
  assign legal = (pri == 6'd31) && (ext == 9'd266);

  // R7
  a_r7_carry_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    !ca);

  // R5
  a_r5_so_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(so) |-> so);

  // R5
  a_r5_ov_implies_so: assert property (@(posedge clk) disable iff (!rst_n)
    ov |-> so);

  // R4
  a_r4_oe_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && legal && !oe) |=> ($stable(ov) && $stable(so)));

  // R6
  a_r6_cr0_form: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && legal && rc) |=> (($countones(cr[3:1]) == 1) && (cr[0] == so)));

  // R6
  a_r6_rc_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && legal && !rc) |=> $stable(cr));

  // R2
  a_r2_write_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && legal) |=> (we && !ill && (waddr == $past(rt[AW-1:0]))));

  // R8
  a_r8_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !legal) |=> (ill && !we && $stable(cr) && $stable(so) && $stable(ov)));

  // R8
  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |=> (!we && !ill));

endmodule

bind fxadd_exec fxadd_exec_chk #(.AW(AW)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .vld   (instr_valid_i),
  .pri   (instr_i[31:26]),
  .ext   (instr_i[9:1]),
  .rt    (instr_i[25:21]),
  .oe    (instr_i[10]),
  .rc    (instr_i[0]),
  .we    (gpr_we_o),
  .waddr (gpr_waddr_o),
  .so    (xer_so_o),
  .ov    (xer_ov_o),
  .ca    (xer_ca_o),
  .cr    (cr0_o),
  .ill   (illegal_o)
);

// File: tb/test_fxadd_exec.sv
`timescale 1ns/1ps
module test_fxadd_exec;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_valid_i;
  logic [31:0] instr_i;
  logic        tp_we_i;
  logic [4:0]  tp_addr_i;
  logic [31:0] tp_wdata_i;
  logic [31:0] tp_rdata_o;
  logic        gpr_we_o;
  logic [4:0]  gpr_waddr_o;
  logic [31:0] gpr_wdata_o;
  logic        xer_so_o, xer_ov_o, xer_ca_o;
  logic [3:0]  cr0_o;
  logic        illegal_o;

  int nchk  = 0;
  int nfail = 0;

  logic [31:0] m_gpr [32];
  logic        m_so, m_ov;
  logic [3:0]  m_cr;

  always #4 clk = ~clk;

  fxadd_exec i_fxadd_exec (
    .clk(clk), .rst_n(rst_n), .instr_valid_i(instr_valid_i), .instr_i(instr_i),
    .tp_we_i(tp_we_i), .tp_addr_i(tp_addr_i), .tp_wdata_i(tp_wdata_i),
    .tp_rdata_o(tp_rdata_o), .gpr_we_o(gpr_we_o), .gpr_waddr_o(gpr_waddr_o),
    .gpr_wdata_o(gpr_wdata_o), .xer_so_o(xer_so_o), .xer_ov_o(xer_ov_o),
    .xer_ca_o(xer_ca_o), .cr0_o(cr0_o), .illegal_o(illegal_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [5:0] p, input logic [4:0] t,
      input logic [4:0] a, input logic [4:0] b, input logic o,
      input logic [8:0] x, input logic r);
    return {p, t, a, b, o, x, r};
  endfunction

  function automatic logic [31:0] pick(input int k);
    case (k)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'h7FFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'hFFFF_FFFF;
      5: return 32'hEFFF_FFFF;
      6: return 32'h8000_7000;
      default: return 32'h7000_8000;
    endcase
  endfunction

  task automatic check_status(input string tag);
    check(xer_so_o == m_so, {tag, " R5 so"}, 32'(xer_so_o), 32'(m_so));
    check(xer_ov_o == m_ov, {tag, " R4 ov"}, 32'(xer_ov_o), 32'(m_ov));
    check(cr0_o == m_cr, {tag, " R6 cr0"}, 32'(cr0_o), 32'(m_cr));
    check(xer_ca_o == 1'b0, {tag, " R7 ca"}, 32'(xer_ca_o), 32'd0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; instr_valid_i = 1'b0; instr_i = '0;
    tp_we_i = 1'b0; tp_addr_i = '0; tp_wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_so = 1'b0; m_ov = 1'b0; m_cr = '0;
    @(negedge clk);
    check_status("R9 reset");
    check(!gpr_we_o && !illegal_o, "R9 reset we/illegal",
          {30'd0, gpr_we_o, illegal_o}, 32'd0);
  endtask

  task automatic tp_wr(input logic [4:0] a, input logic [31:0] d);
    tp_we_i = 1'b1; tp_addr_i = a; tp_wdata_i = d;
    @(negedge clk);
    tp_we_i = 1'b0;
    m_gpr[a] = d;
  endtask

  task automatic tp_chk(input logic [4:0] a, input string tag);
    tp_addr_i = a;
    #1;
    check(tp_rdata_o == m_gpr[a], tag, tp_rdata_o, m_gpr[a]);
  endtask

  task automatic issue(input logic [31:0] w);
    instr_valid_i = 1'b1; instr_i = w;
    @(negedge clk);
    instr_valid_i = 1'b0;
  endtask

  // Executes one add and checks every result against the bench model.
  task automatic run_add(input logic [4:0] t, input logic [4:0] a,
                         input logic [4:0] b, input logic o, input logic r);
    logic [31:0] s;
    logic [32:0] wide;
    logic        v;
    s    = m_gpr[a] + m_gpr[b];
    wide = {m_gpr[a][31], m_gpr[a]} + {m_gpr[b][31], m_gpr[b]};
    v    = wide[32] != wide[31];
    issue(enc(6'd31, t, a, b, o, 9'd266, r));
    if (o) begin
      m_ov = v;
      if (v) m_so = 1'b1;
    end
    if (r) m_cr = {$signed(s) < 0, $signed(s) > 0, s == 32'd0, m_so};
    m_gpr[t] = s;
    check(gpr_we_o == 1'b1, "R2 write pulse", 32'(gpr_we_o), 32'd1);
    check(gpr_waddr_o == t, "R2 write index", 32'(gpr_waddr_o), 32'(t));
    check(gpr_wdata_o == s, "R2 write data", gpr_wdata_o, s);
    check(illegal_o == 1'b0, "R1 legal word", 32'(illegal_o), 32'd0);
    check_status("add");
    tp_chk(t, "R2 target readback");
  endtask

  initial begin
    do_reset();

    // R10: test port load and readback
    for (int i = 0; i < 32; i++) tp_wr(5'(i), 32'h1000_0000 + 32'(i * 3));
    for (int i = 0; i < 32; i++) tp_chk(5'(i), "R10 test port readback");

    // Four forms (overflow-enable, record) over an operand sweep.
    for (int f = 0; f < 4; f++) begin
      if (f == 3) do_reset();
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          int ra, rb, rt;
          ra = (i * 8 + j) % 32;
          rb = (ra + 11) % 32;
          rt = (ra * 3 + f + 1) % 32;
          tp_wr(5'(ra), pick(i));
          tp_wr(5'(rb), pick(j));
          run_add(5'(rt), 5'(ra), 5'(rb), f[1], f[0]);
        end
      end
    end

    // R3: target equals both sources
    tp_wr(5'd5, 32'd3);
    run_add(5'd5, 5'd5, 5'd5, 1'b0, 1'b1);
    check(m_gpr[5] == 32'd6, "R3 old operands used", m_gpr[5], 32'd6);

    // R10: add and test-port write to the same register on one edge
    tp_wr(5'd9, 32'd40);
    tp_wr(5'd10, 32'd2);
    tp_we_i = 1'b1; tp_addr_i = 5'd12; tp_wdata_i = 32'hDEAD_BEEF;
    issue(enc(6'd31, 5'd12, 5'd9, 5'd10, 1'b0, 9'd266, 1'b0));
    tp_we_i = 1'b0;
    m_gpr[12] = 32'd42;
    tp_chk(5'd12, "R10 add wins over test port");

    // R8: every other primary opcode, then every other extended opcode
    tp_wr(5'd7, 32'h5A5A_0007);
    for (int p = 0; p < 64; p++) begin
      if (p != 31) begin
        issue(enc(6'(p), 5'd7, 5'd1, 5'd2, 1'b1, 9'd266, 1'b1));
        check(illegal_o && !gpr_we_o, "R8 R1 bad primary flagged",
              {30'd0, illegal_o, gpr_we_o}, 32'd2);
        check_status("R8 bad primary");
      end
    end
    for (int x = 0; x < 512; x++) begin
      if (x != 266) begin
        issue(enc(6'd31, 5'd7, 5'd3, 5'd4, 1'b1, 9'(x), 1'b1));
        check(illegal_o && !gpr_we_o, "R8 R1 bad extended flagged",
              {30'd0, illegal_o, gpr_we_o}, 32'd2);
        check_status("R8 bad extended");
      end
    end
    tp_chk(5'd7, "R8 target untouched");

    // R8: legal word with valid low
    instr_i = enc(6'd31, 5'd7, 5'd1, 5'd1, 1'b1, 9'd266, 1'b1);
    @(negedge clk);
    check(!gpr_we_o && !illegal_o, "R8 valid low idle",
          {30'd0, gpr_we_o, illegal_o}, 32'd0);
    check_status("R8 valid low");
    tp_chk(5'd7, "R8 valid low target untouched");

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule